// File: doc/BRIEF.md
# Command-Addressed SPI Register Slave

This block is the serial configuration port of a low-rate receiver. An external controller selects it with an active-low chip select and clocks bytes in and out in SPI mode 0. The first byte of every selection is a control byte. Its upper three bits choose an operation and its lower five bits give a starting address. Each further byte in the same selection either writes a configuration register or returns a read byte, and the address advances by one after every data byte. Reads can target the configuration registers, an external receive buffer through a combinational read port, or fixed bytes of two 16-bit test values that the surrounding logic supplies.

The configuration registers drive parallel outputs to the receiver: output select, baud select, three enables, the interrupt enable, a 16-bit bit-quality threshold, two 4-bit frame thresholds, a 12-bit frame word and an 8-bit analog setup byte. The serial pins are brought into the system clock domain through a two-stage synchronizer and sampled there, so the system clock must run several times faster than the serial clock.

Top module: `cspi_cfg_slave`

## Requirements
- R1: While reset is low, and right after it is released, every configuration output and `miso` are 0.
- R2: The control byte is taken MSB first from `mosi` on rising `sck` edges; bits 7..5 are the operation code and bits 4..0 the start address.
- R3: Operation 101 writes each data byte to configuration address 0..7: addr 0 gives out_sel = bits 7:6, baud_sel = 5:4, dec_en = 2, fdet_en = 1, rx_en = 0; addr 1 bit 2 gives int_en; addr 2 and 3 are the high and low threshold bytes; addr 4 gives match_cnt = 7:4 and qual_cnt = 3:0; addr 5 bits 3:0 are frame_word 11:8; addr 6 is frame_word 7:0; addr 7 is ana_setup.
- R4: Written bits with no field (addr 0 bit 3, addr 1 all bits but 2, addr 5 bits 7:4) are dropped and read back as 0.
- R5: Operation 001 returns the stored configuration byte; at addr 1 bit 5 shows the live `irq_flag` input.
- R6: After every data byte the address rises by one for reads and writes; writes to addresses above 7 are ignored and configuration reads above 7 return 0.
- R7: Operation 100 puts the current address on `rxb_addr` and returns `rxb_data` for addresses 0..17 (11h); above that it returns 0.
- R8: Operations 010/011 return the low/high byte of `acc_val` and 110/111 the low/high byte of `stat_val` for every data byte, whatever the address.
- R9: `miso` changes only after a falling `sck` edge or on deselection; the MSB of the first read byte appears on the falling edge that ends the control byte; during the control byte and under operations 101 and 000 `miso` stays 0.
- R10: Only operation 101 changes configuration state; operation 000 and all read operations leave it untouched whatever `mosi` carries.
- R11: If `cs_n` rises before the eighth bit of a byte, that partial byte has no effect and the next selection starts with a new control byte.
- R12: `sck` and `mosi` activity while `cs_n` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| irq_flag | input | 1 | Interrupt request flag shown in register 1 bit 5 |
| acc_val | input | 16 | Accumulator test value |
| stat_val | input | 16 | Statistic test value |
| rxb_addr | output | 5 | Receive buffer read address |
| rxb_data | input | 8 | Receive buffer read data for `rxb_addr` |
| out_sel | output | 2 | Output mux select |
| baud_sel | output | 2 | Baud select |
| dec_en | output | 1 | Decoder enable |
| fdet_en | output | 1 | Frame detector enable |
| rx_en | output | 1 | Receiver enable |
| int_en | output | 1 | Interrupt enable |
| bitq_thr | output | 16 | Bit-quality threshold |
| match_cnt | output | 4 | Required frame-word matches |
| qual_cnt | output | 4 | Required good-quality frame bits |
| frame_word | output | 12 | Frame word |
| ana_setup | output | 8 | Analog setup byte |

## Verification
A serial pin edge becomes an edge pulse after the second synchronizer stage, so `miso` holds the new bit three clock edges after a falling `sck` and a write reaches the configuration outputs four clock edges after the rising `sck` of the byte's eighth bit. The bench holds each `sck` level for eight system clocks and samples `miso` at the end of the low phase just before raising `sck`, well after the three-edge delay. Configuration outputs are compared only after `cs_n` has been high for ten clocks, and a read byte is taken from the eight samples of the byte that follows the one that set its address.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

  localparam int BYTE_W = 8;
  localparam int OP_W   = 3;
  localparam int ADDR_W = 5;
  localparam int TEST_W = 2 * BYTE_W;

  // configuration register indices
  localparam int REG_CTRL  = 0;
  localparam int REG_INTR  = 1;
  localparam int REG_BQ_HI = 2;
  localparam int REG_BQ_LO = 3;
  localparam int REG_FTHR  = 4;
  localparam int REG_FW_HI = 5;
  localparam int REG_FW_LO = 6;
  localparam int REG_ANA   = 7;

  localparam int INTR_IRQ_BIT = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 3'b000,
    OP_CFG_RD  = 3'b001,
    OP_ACC_LO  = 3'b010,
    OP_ACC_HI  = 3'b011,
    OP_RXB_RD  = 3'b100,
    OP_CFG_WR  = 3'b101,
    OP_STAT_LO = 3'b110,
    OP_STAT_HI = 3'b111
  } op_e;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // bits that hold a field in each configuration register
  function automatic logic [BYTE_W-1:0] wr_mask(int idx);
    case (idx)
      REG_CTRL:  return 8'hF7;
      REG_INTR:  return 8'h04;
      REG_FW_HI: return 8'h0F;
      default:   return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cspi_sync.sv
module cspi_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      pipe_d[s] = pipe_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cspi_byte_io.sv
module cspi_byte_io
  import cspi_pkg::*;
#(
  parameter int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cs_act,
  output logic              sck_fall,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);

  logic              sck_d_q;
  logic              sck_rise;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] rx_sh_q, rx_sh_d;
  logic [BYTE_W-1:0] tx_sh_q, tx_sh_d;

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  assign cs_act   = !cs_n_s;
  assign sck_rise = cs_act && sck_s && !sck_d_q;
  assign sck_fall = cs_act && !sck_s && sck_d_q;

  assign byte_done = sck_rise && (bitcnt_q == LAST_BIT);
  assign rx_byte   = {rx_sh_q[BYTE_W-2:0], mosi_s};
  assign miso      = tx_sh_q[BYTE_W-1];

  always_comb begin
    bitcnt_d = bitcnt_q;
    rx_sh_d  = rx_sh_q;
    tx_sh_d  = tx_sh_q;
    if (!cs_act) begin
      // deselection drops any partial byte
      bitcnt_d = '0;
      tx_sh_d  = '0;
    end else begin
      if (sck_rise) begin
        bitcnt_d = bitcnt_q + BIT_W'(1);
        rx_sh_d  = rx_byte;
      end
      if (sck_fall) begin
        // byte boundary: load the next read byte, else shift
        if (bitcnt_q == '0) begin
          tx_sh_d = tx_byte;
        end else begin
          tx_sh_d = {tx_sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q  <= 1'b0;
      bitcnt_q <= '0;
      rx_sh_q  <= '0;
      tx_sh_q  <= '0;
    end else begin
      sck_d_q  <= sck_s;
      bitcnt_q <= bitcnt_d;
      rx_sh_q  <= rx_sh_d;
      tx_sh_q  <= tx_sh_d;
    end
  end

endmodule

// File: rtl/cspi_cmd_ctrl.sv
module cspi_cmd_ctrl
  import cspi_pkg::*;
#(
  parameter int CFG_NUM  = 8,
  parameter int RXB_LAST = 17,
  parameter int CFG_AW   = $clog2(CFG_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] cfg_rd_data,
  input  logic [BYTE_W-1:0] rxb_data,
  input  logic [TEST_W-1:0] acc_val,
  input  logic [TEST_W-1:0] stat_val,
  output logic [ADDR_W-1:0] addr,
  output logic [CFG_AW-1:0] cfg_idx,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              wr_en,
  output logic [CFG_AW-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] CFG_LAST_A = ADDR_W'(CFG_NUM - 1);
  localparam logic [ADDR_W-1:0] RXB_LAST_A = ADDR_W'(RXB_LAST);

  phase_e            phase_q, phase_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_en_q, wr_en_d;
  logic [CFG_AW-1:0] wr_idx_q, wr_idx_d;
  logic [BYTE_W-1:0] wr_data_q, wr_data_d;
  logic              cfg_hit;
  logic              rxb_hit;

  assign cfg_hit = (addr_q <= CFG_LAST_A);
  assign rxb_hit = (addr_q <= RXB_LAST_A);

  // next state
  always_comb begin
    phase_d   = phase_q;
    op_d      = op_q;
    addr_d    = addr_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;
    if (!cs_act) begin
      phase_d = PH_CMD;
    end else if (byte_done) begin
      if (phase_q == PH_CMD) begin
        op_d    = op_e'(rx_byte[BYTE_W-1 -: OP_W]);
        addr_d  = rx_byte[ADDR_W-1:0];
        phase_d = PH_DATA;
      end else begin
        if (op_q == OP_CFG_WR && cfg_hit) begin
          wr_en_d   = 1'b1;
          wr_idx_d  = addr_q[CFG_AW-1:0];
          wr_data_d = rx_byte;
        end
        addr_d = addr_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      op_q      <= OP_NONE;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q   <= phase_d;
      op_q      <= op_d;
      addr_q    <= addr_d;
      wr_en_q   <= wr_en_d;
      wr_idx_q  <= wr_idx_d;
      wr_data_q <= wr_data_d;
    end
  end

  // read byte source for the next byte boundary
  always_comb begin
    tx_byte = '0;
    if (phase_q == PH_DATA) begin
      case (op_q)
        OP_CFG_RD:  tx_byte = cfg_hit ? cfg_rd_data : '0;
        OP_RXB_RD:  tx_byte = rxb_hit ? rxb_data : '0;
        OP_ACC_LO:  tx_byte = acc_val[BYTE_W-1:0];
        OP_ACC_HI:  tx_byte = acc_val[TEST_W-1:BYTE_W];
        OP_STAT_LO: tx_byte = stat_val[BYTE_W-1:0];
        OP_STAT_HI: tx_byte = stat_val[TEST_W-1:BYTE_W];
        default:    tx_byte = '0;
      endcase
    end
  end

  assign addr    = addr_q;
  assign cfg_idx = addr_q[CFG_AW-1:0];
  assign wr_en   = wr_en_q;
  assign wr_idx  = wr_idx_q;
  assign wr_data = wr_data_q;

endmodule

// File: rtl/cspi_cfg_regs.sv
module cspi_cfg_regs
  import cspi_pkg::*;
#(
  parameter int CFG_NUM = 8,
  parameter int CFG_AW  = $clog2(CFG_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CFG_AW-1:0] rd_idx,
  input  logic              irq_flag,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        out_sel,
  output logic [1:0]        baud_sel,
  output logic              dec_en,
  output logic              fdet_en,
  output logic              rx_en,
  output logic              int_en,
  output logic [15:0]       bitq_thr,
  output logic [3:0]        match_cnt,
  output logic [3:0]        qual_cnt,
  output logic [11:0]       frame_word,
  output logic [7:0]        ana_setup
);

  logic [CFG_NUM-1:0][BYTE_W-1:0] reg_q, reg_d, mask_vec;

  for (genvar i = 0; i < CFG_NUM; i++) begin : g_mask
    assign mask_vec[i] = wr_mask(i);
  end

  always_comb begin
    reg_d         = reg_q;
    reg_d[wr_idx] = wr_data & mask_vec[wr_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_en) begin
      reg_q <= reg_d;
    end
  end

  always_comb begin
    rd_data = reg_q[rd_idx];
    if (rd_idx == CFG_AW'(REG_INTR)) begin
      rd_data[INTR_IRQ_BIT] = irq_flag;
    end
  end

  assign out_sel    = reg_q[REG_CTRL][7:6];
  assign baud_sel   = reg_q[REG_CTRL][5:4];
  assign dec_en     = reg_q[REG_CTRL][2];
  assign fdet_en    = reg_q[REG_CTRL][1];
  assign rx_en      = reg_q[REG_CTRL][0];
  assign int_en     = reg_q[REG_INTR][2];
  assign bitq_thr   = {reg_q[REG_BQ_HI], reg_q[REG_BQ_LO]};
  assign match_cnt  = reg_q[REG_FTHR][7:4];
  assign qual_cnt   = reg_q[REG_FTHR][3:0];
  assign frame_word = {reg_q[REG_FW_HI][3:0], reg_q[REG_FW_LO]};
  assign ana_setup  = reg_q[REG_ANA];

endmodule

// File: rtl/cspi_cfg_slave.sv
module cspi_cfg_slave
  import cspi_pkg::*;
#(
  parameter int CFG_NUM     = 8,
  parameter int RXB_LAST    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic              irq_flag,
  input  logic [TEST_W-1:0] acc_val,
  input  logic [TEST_W-1:0] stat_val,
  output logic [ADDR_W-1:0] rxb_addr,
  input  logic [BYTE_W-1:0] rxb_data,
  output logic [1:0]        out_sel,
  output logic [1:0]        baud_sel,
  output logic              dec_en,
  output logic              fdet_en,
  output logic              rx_en,
  output logic              int_en,
  output logic [15:0]       bitq_thr,
  output logic [3:0]        match_cnt,
  output logic [3:0]        qual_cnt,
  output logic [11:0]       frame_word,
  output logic [7:0]        ana_setup
);

  localparam int CFG_AW = $clog2(CFG_NUM);

  logic              cs_n_s, sck_s, mosi_s;
  logic              cs_act, sck_fall, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [CFG_AW-1:0] cfg_idx, wr_idx;
  logic [BYTE_W-1:0] cfg_rd_data, wr_data;
  logic              wr_en;

  cspi_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sck, mosi}),
    .q     ({cs_n_s, sck_s, mosi_s})
  );

  cspi_byte_io u_io (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .tx_byte   (tx_byte),
    .cs_act    (cs_act),
    .sck_fall  (sck_fall),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (miso)
  );

  cspi_cmd_ctrl #(
    .CFG_NUM  (CFG_NUM),
    .RXB_LAST (RXB_LAST),
    .CFG_AW   (CFG_AW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .cfg_rd_data (cfg_rd_data),
    .rxb_data    (rxb_data),
    .acc_val     (acc_val),
    .stat_val    (stat_val),
    .addr        (rxb_addr),
    .cfg_idx     (cfg_idx),
    .tx_byte     (tx_byte),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data)
  );

  cspi_cfg_regs #(
    .CFG_NUM (CFG_NUM),
    .CFG_AW  (CFG_AW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_idx     (cfg_idx),
    .irq_flag   (irq_flag),
    .rd_data    (cfg_rd_data),
    .out_sel    (out_sel),
    .baud_sel   (baud_sel),
    .dec_en     (dec_en),
    .fdet_en    (fdet_en),
    .rx_en      (rx_en),
    .int_en     (int_en),
    .bitq_thr   (bitq_thr),
    .match_cnt  (match_cnt),
    .qual_cnt   (qual_cnt),
    .frame_word (frame_word),
    .ana_setup  (ana_setup)
  );

endmodule

// File: rtl/cspi_cfg_slave_chk.sv
module cspi_cfg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miso,
  input logic        cs_act,
  input logic        sck_fall,
  input logic        byte_done,
  input logic        wr_en,
  input logic        int_en,
  input logic [15:0] bitq_thr,
  input logic [11:0] frame_word,
  input logic [7:0]  ana_setup
);

  // R9: serial output moves only after a falling clock edge or deselection
  assert_miso_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sck_fall || !cs_act));

  // R12: no register write while the slave has been deselected
  assert_no_write_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !wr_en);

  // R12: a byte can only complete inside a selection
  assert_byte_in_xfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> cs_act);

  // R11: every write strobe follows a fully received byte
  assert_write_after_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_done));

  // R10: configuration outputs change only after a write strobe
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({int_en, bitq_thr, frame_word, ana_setup}) |-> $past(wr_en));

endmodule

bind cspi_cfg_slave cspi_cfg_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miso       (miso),
  .cs_act     (cs_act),
  .sck_fall   (sck_fall),
  .byte_done  (byte_done),
  .wr_en      (wr_en),
  .int_en     (int_en),
  .bitq_thr   (bitq_thr),
  .frame_word (frame_word),
  .ana_setup  (ana_setup)
);

// File: tb/tb_cspi_cfg_slave.sv
`timescale 1ns/1ps
module tb_cspi_cfg_slave;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, mosi, irq_flag;
  logic        miso;
  logic [15:0] acc_val, stat_val;
  logic [4:0]  rxb_addr;
  logic [7:0]  rxb_data;
  logic [1:0]  out_sel, baud_sel;
  logic        dec_en, fdet_en, rx_en, int_en;
  logic [15:0] bitq_thr;
  logic [3:0]  match_cnt, qual_cnt;
  logic [11:0] frame_word;
  logic [7:0]  ana_setup;

  always #4 clk = ~clk;

  // external receive buffer model
  function automatic logic [7:0] rxb_fn(input logic [4:0] a);
    return {a[2:0], a} ^ 8'h5A;
  endfunction
  assign rxb_data = rxb_fn(rxb_addr);

  cspi_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .irq_flag(irq_flag), .acc_val(acc_val), .stat_val(stat_val),
    .rxb_addr(rxb_addr), .rxb_data(rxb_data),
    .out_sel(out_sel), .baud_sel(baud_sel), .dec_en(dec_en), .fdet_en(fdet_en),
    .rx_en(rx_en), .int_en(int_en), .bitq_thr(bitq_thr), .match_cnt(match_cnt),
    .qual_cnt(qual_cnt), .frame_word(frame_word), .ana_setup(ana_setup)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [8];
  logic [7:0] wdat [24];
  logic [7:0] rdat [24];

  wire [51:0] act_cfg = {out_sel, baud_sel, dec_en, fdet_en, rx_en, int_en,
                         bitq_thr, match_cnt, qual_cnt, frame_word, ana_setup};

  function automatic logic [7:0] fmask(input int a);
    case (a)
      0: return 8'hF7;
      1: return 8'h04;
      5: return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [51:0] exp_cfg();
    return {mdl[0][7:6], mdl[0][5:4], mdl[0][2], mdl[0][1], mdl[0][0], mdl[1][2],
            mdl[2], mdl[3], mdl[4][7:4], mdl[4][3:0], mdl[5][3:0], mdl[6], mdl[7]};
  endfunction

  function automatic logic [7:0] cfg_rd_exp(input int a);
    if (a > 7) return 8'h00;
    if (a == 1) return mdl[1] | {2'b00, irq_flag, 5'b00000};
    return mdl[a];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb);
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = tx[b];
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      tick(HALF);
      rx[b] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_stop();
    tick(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    tick(10);
  endtask

  task automatic xact(input logic [7:0] ctl, input int n);
    logic [7:0] r;
    cs_n = 1'b0;
    tick(4);
    xfer_byte(ctl, r);
    check("R9 miso during control byte", r, 0);
    for (int i = 0; i < n; i++) begin
      xfer_byte(wdat[i], r);
      rdat[i] = r;
    end
    cs_stop();
  endtask

  task automatic do_write(input int start, input int n);
    xact({3'b101, 5'(start)}, n);
    for (int i = 0; i < n; i++) begin
      if (start + i < 8) mdl[start+i] = wdat[i] & fmask(start + i);
      check("R9 miso under write", rdat[i], 0);
    end
  endtask

  task automatic rd_cfg(input int start, input int n, input string req);
    xact({3'b001, 5'(start)}, n);
    for (int i = 0; i < n; i++) check(req, rdat[i], cfg_rd_exp(start + i));
  endtask

  initial begin
    void'($urandom(32'h5EED_0C11));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; irq_flag = 1'b0;
    acc_val = 16'hC3A5; stat_val = 16'h5E17;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    for (int i = 0; i < 24; i++) wdat[i] = 8'h00;
    tick(2);
    check("R1 config outputs in reset", act_cfg, 0);
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check("R1 config outputs after reset", act_cfg, 0);
    check("R1 miso after reset", miso, 0);

    // all-ones burst from address 0 (R3, R4, R6)
    for (int i = 0; i < 8; i++) wdat[i] = 8'hFF;
    do_write(0, 8);
    check("R4 unused bits dropped", act_cfg, exp_cfg());
    irq_flag = 1'b1;
    rd_cfg(0, 10, "R4/R5/R6 readback with auto-increment");
    irq_flag = 1'b0;
    rd_cfg(1, 1, "R5 irq bit clear");

    // distinct values burst (R2, R3)
    wdat[0] = 8'h96; wdat[1] = 8'hFB; wdat[2] = 8'h12; wdat[3] = 8'h34;
    wdat[4] = 8'hA7; wdat[5] = 8'hE9; wdat[6] = 8'h5C; wdat[7] = 8'h3D;
    do_write(0, 8);
    check("R2/R3 field mapping", act_cfg, exp_cfg());
    rd_cfg(6, 4, "R6 read past last register");

    // write starting at the last register: extra bytes ignored (R6)
    wdat[0] = 8'h81; wdat[1] = 8'h77; wdat[2] = 8'h66;
    do_write(7, 3);
    check("R6 writes above 7 ignored", act_cfg, exp_cfg());

    // receive buffer reads across the top boundary (R7)
    xact({3'b100, 5'h0F}, 5);
    for (int i = 0; i < 5; i++)
      check("R7 receive buffer read", rdat[i], (15 + i <= 17) ? rxb_fn(5'(15 + i)) : 8'h00);
    xact({3'b100, 5'h00}, 2);
    for (int i = 0; i < 2; i++) check("R7 receive buffer low", rdat[i], rxb_fn(5'(i)));

    // test value reads (R8)
    xact({3'b010, 5'($urandom_range(0, 31))}, 3);
    for (int i = 0; i < 3; i++) check("R8 acc low", rdat[i], acc_val[7:0]);
    xact({3'b011, 5'($urandom_range(0, 31))}, 2);
    for (int i = 0; i < 2; i++) check("R8 acc high", rdat[i], acc_val[15:8]);
    xact({3'b110, 5'($urandom_range(0, 31))}, 2);
    for (int i = 0; i < 2; i++) check("R8 stat low", rdat[i], stat_val[7:0]);
    xact({3'b111, 5'($urandom_range(0, 31))}, 2);
    for (int i = 0; i < 2; i++) check("R8 stat high", rdat[i], stat_val[15:8]);

    // undefined and read commands carrying data (R10)
    for (int i = 0; i < 4; i++) wdat[i] = 8'($urandom);
    xact({3'b000, 5'd2}, 4);
    for (int i = 0; i < 4; i++) check("R9 miso under undefined op", rdat[i], 0);
    check("R10 undefined op no write", act_cfg, exp_cfg());
    rd_cfg(3, 4, "R10 read op data");
    check("R10 read op no write", act_cfg, exp_cfg());

    // abort in the middle of a data byte (R11)
    cs_n = 1'b0; tick(4);
    begin
      logic [7:0] r;
      xfer_byte({3'b101, 5'd6}, r);
    end
    xfer_bits(8'h99, 5);
    tick(HALF); cs_n = 1'b1; tick(10);
    check("R11 partial data byte dropped", act_cfg, exp_cfg());
    rd_cfg(6, 1, "R11 new control byte after abort");

    // abort in the middle of a control byte (R11)
    cs_n = 1'b0; tick(4);
    xfer_bits(8'hA6, 5);
    tick(HALF); cs_n = 1'b1; tick(10);
    wdat[0] = 8'h9C;
    do_write(4, 1);
    check("R11 clean start after control abort", act_cfg, exp_cfg());

    // clock activity while deselected (R12)
    xfer_bits(8'hA2, 8);
    xfer_bits(8'hFF, 8);
    tick(10);
    check("R12 deselected clocks ignored", act_cfg, exp_cfg());
    rd_cfg(2, 2, "R12 next transfer normal");

    // random write bursts checked against the model
    for (int it = 0; it < 20; it++) begin
      int st, ln;
      st = $urandom_range(0, 7);
      ln = $urandom_range(1, 4);
      for (int i = 0; i < ln; i++) wdat[i] = 8'($urandom);
      do_write(st, ln);
      check("R3/R4/R6 random burst", act_cfg, exp_cfg());
      if (it % 4 == 0) begin
        irq_flag = 1'($urandom);
        rd_cfg($urandom_range(0, 6), 3, "R5/R6 random readback");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule